// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block keeps the program order of every instruction between decode and retirement. Decode writes one entry per cycle at the tail of a circular queue. The entry holds the destination architectural register, the newly assigned physical register, the physical register that the new one displaces, a store flag and a destination flag. Execution units report completion by entry index, and they can attach a fault mark for an exception or a mispredicted branch. An interrupt request marks whichever entry sits at the head.

Each cycle the commit window looks at up to `COMMIT_W` entries starting at the head. It retires the leading run of completed entries. For each retired entry it hands the displaced physical register back to the free list, releases retired stores to memory in order, and updates a retirement mapping table. When a marked entry retires, the block raises a one-cycle flush. During that cycle the rename table reloads from the retirement mapping table, the queue is empty and decode is held off.

Top module: `rob_commit_unit`

## Requirements
- R1: After reset the allocation index starts at 0 and advances by one, modulo `DEPTH`, on each accepted allocation. `alloc_ready` is low whenever `DEPTH` entries are outstanding, and a request made while it is low is ignored.
- R2: An entry becomes eligible to retire only after a completion has named its index. An entry that has not completed blocks every younger entry.
- R3: In each cycle at most `COMMIT_W` entries retire. They form a contiguous run from the head that ends at the first entry that has not completed. `ret_count` gives the size of the run one cycle later.
- R4: For every retired entry with a destination, slot k of `ret_free_vld`/`ret_free_phys` returns that entry's displaced physical register. Slot 0 is the oldest. Entries without a destination return nothing.
- R5: The retirement mapping table resets to the identity map (architectural i to physical i). Each retired entry with a destination writes its new physical register into it, and the youngest entry in a group wins. `restore_map` exposes the table, with architectural register a at bits [a*PHYS_W +: PHYS_W].
- R6: A store is released on `ret_store_vld` only in the cycle after it retires, in its slot of the retire group.
- R7: A completion with the fault flag marks its entry. The marked entry retires and still updates the free list and the mapping table. No younger entry of the same group retires, and `flush_o` pulses high for one cycle afterwards.
- R8: An `irq_mark` pulse marks the entry at the head if the queue is not empty. That entry then triggers the flush when it retires.
- R9: In the flush cycle the queue is empty, `alloc_ready` is low and the allocation index is 0. An allocation offered in the cycle in which the marked entry retires is discarded.
- R10: Reset clears the queue and all retire outputs, and it leaves `alloc_ready` high.

Ports for the default parameters (`DEPTH`=16, `COMMIT_W`=4, `ARCH_REGS`=16, `PHYS_W`=7):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Decode offers a new entry |
| alloc_has_dest | input | 1 | Entry writes a register |
| alloc_arch | input | 4 | Destination architectural register |
| alloc_new_phys | input | 7 | Newly assigned physical register |
| alloc_prev_phys | input | 7 | Physical register displaced by this entry |
| alloc_is_store | input | 1 | Entry is a store |
| alloc_ready | output | 1 | An entry can be accepted this cycle |
| alloc_idx | output | 4 | Index given to the entry accepted this cycle |
| done_valid | input | 1 | A completion is reported |
| done_idx | input | 4 | Index of the completed entry |
| done_fault | input | 1 | Completion carries an exception or mispredict mark |
| irq_mark | input | 1 | Mark the current head entry for an interrupt |
| ret_free_vld | output | 4 | Per slot: a physical register is returned |
| ret_free_phys | output | 28 | Per slot: returned physical register |
| ret_store_vld | output | 4 | Per slot: a store is released to memory |
| ret_count | output | 3 | Entries retired in the previous cycle |
| flush_o | output | 1 | One-cycle recovery pulse |
| restore_map | output | 112 | Retirement mapping table contents |

## Verification
On every cycle, the assertions check the following:
- the occupancy never exceeds the queue depth;
- the retire group is always a contiguous prefix;
- freed registers appear only with a non-zero retire count;
- the flush pulse lasts exactly one cycle, with the queue empty and allocation blocked;
- a freshly allocated entry starts out not completed;
- the mapping table holds still when nothing with a destination retires.

Some properties need particular sequences from the bench's scenarios:
- the group stops at an incomplete entry or just after a marked one;
- the youngest write wins in the mapping table;
- an interrupt lands on the head;
- an allocation offered in the retire cycle of a marked entry is dropped.

The cycle-by-cycle reference model checks these.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic {
    PH_RUN     = 1'b0,
    PH_RECOVER = 1'b1
  } rob_phase_e;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
  parameter int DEPTH   = 16,
  parameter int SLOTS   = 4,
  parameter int ARCH_W  = 4,
  parameter int PHYS_W  = 7,
  localparam int IW     = rob_pkg::idx_bits(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_ptr,
  input  logic                     wr_dest,
  input  logic [ARCH_W-1:0]        wr_arch,
  input  logic [PHYS_W-1:0]        wr_newp,
  input  logic [PHYS_W-1:0]        wr_prevp,
  input  logic                     wr_store,
  input  logic                     cpl_valid,
  input  logic [IW-1:0]            cpl_idx,
  input  logic                     cpl_fault,
  input  logic                     head_mark,
  input  logic [IW-1:0]            head,
  output logic [SLOTS-1:0]         s_rdy,
  output logic [SLOTS-1:0]         s_mark,
  output logic [SLOTS-1:0]         s_dest,
  output logic [SLOTS-1:0]         s_store,
  output logic [SLOTS*ARCH_W-1:0]  s_arch,
  output logic [SLOTS*PHYS_W-1:0]  s_newp,
  output logic [SLOTS*PHYS_W-1:0]  s_prevp
);
  logic [DEPTH-1:0]   rdy_q;
  logic [DEPTH-1:0]   mark_q;
  logic [DEPTH-1:0]   dest_mem;
  logic [DEPTH-1:0]   store_mem;
  logic [ARCH_W-1:0]  arch_mem  [DEPTH];
  logic [PHYS_W-1:0]  newp_mem  [DEPTH];
  logic [PHYS_W-1:0]  prevp_mem [DEPTH];

  // payload: write-only at allocation, RAM style
  always_ff @(posedge clk) begin
    if (wr_en) begin
      dest_mem[wr_ptr]  <= wr_dest;
      store_mem[wr_ptr] <= wr_store;
      arch_mem[wr_ptr]  <= wr_arch;
      newp_mem[wr_ptr]  <= wr_newp;
      prevp_mem[wr_ptr] <= wr_prevp;
    end
  end

  // status bits: completion, fault and interrupt marks
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q  <= '0;
      mark_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && wr_ptr == IW'(i)) begin
          rdy_q[i]  <= 1'b0;
          mark_q[i] <= 1'b0;
        end else begin
          if (cpl_valid && cpl_idx == IW'(i)) begin
            rdy_q[i] <= 1'b1;
            if (cpl_fault) mark_q[i] <= 1'b1;
          end
          if (head_mark && head == IW'(i)) mark_q[i] <= 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [IW-1:0] ridx;
    assign ridx    = head + IW'(k);
    assign s_rdy[k]   = rdy_q[ridx];
    assign s_mark[k]  = mark_q[ridx];
    assign s_dest[k]  = dest_mem[ridx];
    assign s_store[k] = store_mem[ridx];
    assign s_arch[k*ARCH_W +: ARCH_W]  = arch_mem[ridx];
    assign s_newp[k*PHYS_W +: PHYS_W]  = newp_mem[ridx];
    assign s_prevp[k*PHYS_W +: PHYS_W] = prevp_mem[ridx];
  end

  AST_ALLOC_STARTS_PENDING: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !rdy_q[$past(wr_ptr)]); // R2
endmodule

// File: rtl/rob_commit_window.sv
module rob_commit_window #(
  parameter int SLOTS = 4,
  parameter int CNT_W = 5,
  parameter int CW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SLOTS-1:0] rdy,
  input  logic [SLOTS-1:0] mark,
  input  logic [CNT_W-1:0] occupancy,
  output logic [SLOTS-1:0] take,
  output logic             hit_mark,
  output logic [CW-1:0]    ntake
);
  logic go;

  always_comb begin
    go       = 1'b1;
    take     = '0;
    hit_mark = 1'b0;
    ntake    = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (go && occupancy > CNT_W'(k) && rdy[k]) begin
        take[k] = 1'b1;
        ntake   = ntake + CW'(1);
        if (mark[k]) begin
          hit_mark = 1'b1;
          go       = 1'b0;
        end
      end else begin
        go = 1'b0;
      end
    end
  end

  AST_COMMIT_PREFIX: assert property (@(posedge clk) disable iff (rst)
    ((take & (take + SLOTS'(1))) == '0)); // R3
endmodule

// File: rtl/rob_retire_table.sv
module rob_retire_table #(
  parameter int ARCH_REGS = 16,
  parameter int SLOTS     = 4,
  parameter int PHYS_W    = 7,
  localparam int ARCH_W   = rob_pkg::idx_bits(ARCH_REGS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SLOTS-1:0]            upd,
  input  logic [SLOTS*ARCH_W-1:0]     upd_arch,
  input  logic [SLOTS*PHYS_W-1:0]     upd_phys,
  output logic [ARCH_REGS*PHYS_W-1:0] table_flat
);
  logic [PHYS_W-1:0] tbl [ARCH_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_REGS; i++) tbl[i] <= PHYS_W'(i);
    end else begin
      // ascending slot order: the youngest write of a group lands last
      for (int k = 0; k < SLOTS; k++) begin
        if (upd[k]) tbl[upd_arch[k*ARCH_W +: ARCH_W]] <= upd_phys[k*PHYS_W +: PHYS_W];
      end
    end
  end

  for (genvar a = 0; a < ARCH_REGS; a++) begin : g_out
    assign table_flat[a*PHYS_W +: PHYS_W] = tbl[a];
  end

  AST_TABLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (upd == '0) |=> $stable(table_flat)); // R5
endmodule

// File: rtl/rob_commit_unit.sv
module rob_commit_unit #(
  parameter int DEPTH      = 16,
  parameter int COMMIT_W   = 4,
  parameter int ARCH_REGS  = 16,
  parameter int PHYS_W     = 7,
  localparam int IW        = rob_pkg::idx_bits(DEPTH),
  localparam int AW        = rob_pkg::idx_bits(ARCH_REGS),
  localparam int CW        = $clog2(COMMIT_W + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        alloc_valid,
  input  logic                        alloc_has_dest,
  input  logic [AW-1:0]               alloc_arch,
  input  logic [PHYS_W-1:0]           alloc_new_phys,
  input  logic [PHYS_W-1:0]           alloc_prev_phys,
  input  logic                        alloc_is_store,
  output logic                        alloc_ready,
  output logic [IW-1:0]               alloc_idx,
  input  logic                        done_valid,
  input  logic [IW-1:0]               done_idx,
  input  logic                        done_fault,
  input  logic                        irq_mark,
  output logic [COMMIT_W-1:0]         ret_free_vld,
  output logic [COMMIT_W*PHYS_W-1:0]  ret_free_phys,
  output logic [COMMIT_W-1:0]         ret_store_vld,
  output logic [CW-1:0]               ret_count,
  output logic                        flush_o,
  output logic [ARCH_REGS*PHYS_W-1:0] restore_map
);
  import rob_pkg::*;
  localparam int CNT_W = IW + 1;

  logic [IW-1:0]    head_q, tail_q;
  logic [CNT_W-1:0] occ_q;
  rob_phase_e       phase_q;

  logic                       alloc_fire;
  logic [COMMIT_W-1:0]        s_rdy, s_mark, s_dest, s_store, take;
  logic [COMMIT_W*AW-1:0]     s_arch;
  logic [COMMIT_W*PHYS_W-1:0] s_newp, s_prevp;
  logic                       hit_mark;
  logic [CW-1:0]              ntake;

  assign alloc_ready = (occ_q < CNT_W'(DEPTH)) && (phase_q == PH_RUN);
  assign alloc_idx   = tail_q;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign flush_o     = (phase_q == PH_RECOVER);

  rob_entry_store #(
    .DEPTH(DEPTH), .SLOTS(COMMIT_W), .ARCH_W(AW), .PHYS_W(PHYS_W)
  ) i_store (
    .clk(clk), .rst(rst),
    .wr_en(alloc_fire), .wr_ptr(tail_q), .wr_dest(alloc_has_dest),
    .wr_arch(alloc_arch), .wr_newp(alloc_new_phys), .wr_prevp(alloc_prev_phys),
    .wr_store(alloc_is_store),
    .cpl_valid(done_valid), .cpl_idx(done_idx), .cpl_fault(done_fault),
    .head_mark(irq_mark && occ_q != '0 && phase_q == PH_RUN), .head(head_q),
    .s_rdy(s_rdy), .s_mark(s_mark), .s_dest(s_dest), .s_store(s_store),
    .s_arch(s_arch), .s_newp(s_newp), .s_prevp(s_prevp)
  );

  rob_commit_window #(.SLOTS(COMMIT_W), .CNT_W(CNT_W), .CW(CW)) i_window (
    .clk(clk), .rst(rst), .rdy(s_rdy), .mark(s_mark), .occupancy(occ_q),
    .take(take), .hit_mark(hit_mark), .ntake(ntake)
  );

  rob_retire_table #(.ARCH_REGS(ARCH_REGS), .SLOTS(COMMIT_W), .PHYS_W(PHYS_W)) i_rtable (
    .clk(clk), .rst(rst), .upd(take & s_dest), .upd_arch(s_arch),
    .upd_phys(s_newp), .table_flat(restore_map)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      occ_q   <= '0;
      phase_q <= PH_RUN;
    end else if (hit_mark) begin
      head_q  <= '0;
      tail_q  <= '0;
      occ_q   <= '0;
      phase_q <= PH_RECOVER;
    end else begin
      head_q  <= head_q + IW'(ntake);
      tail_q  <= tail_q + IW'(alloc_fire);
      occ_q   <= occ_q + CNT_W'(alloc_fire) - CNT_W'(ntake);
      phase_q <= PH_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_free_vld  <= '0;
      ret_free_phys <= '0;
      ret_store_vld <= '0;
      ret_count     <= '0;
    end else begin
      ret_free_vld  <= take & s_dest;
      ret_free_phys <= s_prevp;
      ret_store_vld <= take & s_store;
      ret_count     <= ntake;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ_q <= CNT_W'(DEPTH)); // R1
  AST_RETIRE_BOUND: assert property (@(posedge clk) disable iff (rst)
    ret_count <= CW'(COMMIT_W)); // R3
  AST_FREE_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (rst)
    (ret_free_vld != '0) |-> (ret_count != '0)); // R4
  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> !flush_o); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> (occ_q == '0 && !alloc_ready && alloc_idx == '0)); // R9
endmodule

// File: tb/test_rob_commit_unit.sv
module test_rob_commit_unit;
  localparam int D = 16, W = 4, A = 16, P = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_valid = 0, alloc_has_dest = 0, alloc_is_store = 0;
  logic [3:0] alloc_arch = '0;
  logic [P-1:0] alloc_new_phys = '0, alloc_prev_phys = '0;
  logic alloc_ready;
  logic [3:0] alloc_idx;
  logic done_valid = 0, done_fault = 0, irq_mark = 0;
  logic [3:0] done_idx = '0;
  logic [W-1:0] ret_free_vld, ret_store_vld;
  logic [W*P-1:0] ret_free_phys;
  logic [2:0] ret_count;
  logic flush_o;
  logic [A*P-1:0] restore_map;

  always #2.5 clk = ~clk;

  rob_commit_unit i_rob_commit_unit (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_has_dest(alloc_has_dest),
    .alloc_arch(alloc_arch), .alloc_new_phys(alloc_new_phys), .alloc_prev_phys(alloc_prev_phys),
    .alloc_is_store(alloc_is_store), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .done_valid(done_valid), .done_idx(done_idx), .done_fault(done_fault), .irq_mark(irq_mark),
    .ret_free_vld(ret_free_vld), .ret_free_phys(ret_free_phys), .ret_store_vld(ret_store_vld),
    .ret_count(ret_count), .flush_o(flush_o), .restore_map(restore_map)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    int idx; bit dest; int arch; int newp; int prevp; bit st; bit rdy; bit mk;
  } ent_t;
  ent_t q[$];
  int tail = 0;
  int rmap[A];
  int e_count = 0;
  bit e_flush = 0;
  bit e_fv[W];
  int e_fp[W];
  bit e_sv[W];
  int n_m;
  bit fl_m, ar_m;
  ent_t ne;

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); tail = 0; e_count = 0; e_flush = 0;
      for (int a = 0; a < A; a++) rmap[a] = a;
      for (int k = 0; k < W; k++) begin e_fv[k] = 0; e_fp[k] = 0; e_sv[k] = 0; end
    end else begin
      ar_m = (q.size() < D) && !e_flush;
      n_m = 0; fl_m = 0;
      for (int k = 0; k < W; k++) begin e_fv[k] = 0; e_sv[k] = 0; end
      for (int k = 0; k < W; k++) begin
        if (k >= q.size() || fl_m) break;
        if (!q[k].rdy) break;
        if (q[k].dest) begin
          e_fv[k] = 1; e_fp[k] = q[k].prevp; rmap[q[k].arch] = q[k].newp;
        end
        if (q[k].st) e_sv[k] = 1;
        n_m++;
        if (q[k].mk) fl_m = 1;
      end
      if (done_valid)
        for (int i = 0; i < q.size(); i++)
          if (q[i].idx == int'(done_idx)) begin
            q[i].rdy = 1;
            if (done_fault) q[i].mk = 1;
          end
      if (irq_mark && q.size() > 0 && !e_flush) q[0].mk = 1;
      for (int i = 0; i < n_m; i++) void'(q.pop_front());
      if (fl_m) begin
        q.delete(); tail = 0;
      end else if (alloc_valid && ar_m) begin
        ne.idx = tail; ne.dest = alloc_has_dest; ne.arch = int'(alloc_arch);
        ne.newp = int'(alloc_new_phys); ne.prevp = int'(alloc_prev_phys);
        ne.st = alloc_is_store; ne.rdy = 0; ne.mk = 0;
        q.push_back(ne);
        tail = (tail + 1) % D;
      end
      e_count = n_m; e_flush = fl_m;
    end
  end

  // ---------------- per-cycle comparison ----------------
  int tot_commit = 0, max_count = 0, nflush = 0, count_at_flush = -1;
  bit map_ok;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(alloc_ready == ((q.size() < D) && !e_flush), "R1 alloc_ready", alloc_ready, (q.size() < D) && !e_flush);
      chk(int'(alloc_idx) == tail, "R1 alloc_idx", alloc_idx, tail);
      chk(int'(ret_count) == e_count, "R3 ret_count", ret_count, e_count);
      chk(flush_o == e_flush, "R7 flush_o", flush_o, e_flush);
      for (int k = 0; k < W; k++) begin
        chk(ret_free_vld[k] == e_fv[k], "R4 ret_free_vld", ret_free_vld[k], e_fv[k]);
        if (e_fv[k])
          chk(int'(ret_free_phys[k*P +: P]) == e_fp[k], "R4 ret_free_phys", ret_free_phys[k*P +: P], e_fp[k]);
        chk(ret_store_vld[k] == e_sv[k], "R6 ret_store_vld", ret_store_vld[k], e_sv[k]);
      end
      map_ok = 1;
      for (int a = 0; a < A; a++) if (int'(restore_map[a*P +: P]) != rmap[a]) map_ok = 0;
      chk(map_ok, "R5 restore_map", map_ok, 1);
      if (flush_o) begin
        chk(!alloc_ready, "R9 alloc blocked in recovery", alloc_ready, 0);
        nflush++; count_at_flush = ret_count;
      end
      tot_commit += ret_count;
      if (int'(ret_count) > max_count) max_count = ret_count;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic alloc_one(input bit d, input int arch, input int np, input int pp, input bit st);
    alloc_valid = 1; alloc_has_dest = d; alloc_arch = 4'(arch);
    alloc_new_phys = P'(np); alloc_prev_phys = P'(pp); alloc_is_store = st;
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic done_one(input int idx, input bit f);
    done_valid = 1; done_idx = 4'(idx % D); done_fault = f;
    @(negedge clk);
    done_valid = 0; done_fault = 0;
  endtask

  int base, t0, f0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: reset state
    chk(alloc_ready == 1, "R10 alloc_ready after reset", alloc_ready, 1);
    chk(alloc_idx == 0, "R10 alloc_idx after reset", alloc_idx, 0);
    chk(ret_count == 0 && ret_free_vld == 0 && !flush_o, "R10 retire outputs quiet", ret_count, 0);
    chk(int'(restore_map[3*P +: P]) == 3, "R10/R5 identity map", restore_map[3*P +: P], 3);

    // S1: R2 out-of-order completion, head blocks
    base = tail;
    for (int i = 0; i < 4; i++) alloc_one(1, i + 1, 20 + i, i + 1, 0);
    t0 = tot_commit;
    done_one(base + 0, 0); done_one(base + 1, 0); done_one(base + 3, 0);
    idle(3);
    chk(tot_commit - t0 == 2, "R2 stops at incomplete entry", tot_commit - t0, 2);
    done_one(base + 2, 0);
    idle(3);
    chk(tot_commit - t0 == 4, "R2 remaining entries retire", tot_commit - t0, 4);

    // S2: R3 width limit, R5 youngest wins (arch 9 written twice)
    base = tail;
    for (int i = 0; i < 6; i++) alloc_one(1, (i < 2) ? 9 : 10 + i, 40 + i, 60 + i, 0);
    for (int i = 5; i >= 0; i--) done_one(base + i, 0);
    idle(4);
    chk(max_count == W, "R3 group capped at width", max_count, W);
    chk(int'(restore_map[9*P +: P]) == 41, "R5 youngest mapping wins", restore_map[9*P +: P], 41);

    // S3: R6 stores and entries without a destination
    base = tail;
    alloc_one(0, 0, 0, 0, 1); alloc_one(1, 2, 70, 2, 0); alloc_one(0, 0, 0, 0, 1);
    done_one(base + 2, 0); done_one(base + 0, 0); done_one(base + 1, 0);
    idle(4);

    // S4: R1 fill to capacity
    base = tail;
    for (int i = 0; i < D; i++) alloc_one(1, i % A, 80 + i % 40, 1 + i, i % 3 == 0);
    chk(alloc_ready == 0, "R1 full blocks allocation", alloc_ready, 0);
    alloc_one(1, 1, 5, 5, 0);
    chk(int'(alloc_idx) == base % D, "R1 request ignored when full", alloc_idx, base % D);
    for (int i = 0; i < D; i++) done_one(base + i, 0);
    idle(6);

    // S5: R7 fault in mid group, younger entries dropped
    base = tail;
    for (int i = 0; i < 4; i++) alloc_one(1, 5 + i, 100 + i, 50 + i, 0);
    f0 = nflush;
    done_one(base + 1, 1); done_one(base + 2, 0); done_one(base + 3, 0); done_one(base + 0, 0);
    idle(3);
    chk(nflush - f0 == 1, "R7 one flush pulse", nflush - f0, 1);
    chk(count_at_flush == 2, "R7 younger entries not retired", count_at_flush, 2);
    chk(alloc_idx == 0, "R9 index restarts after recovery", alloc_idx, 0);

    // S6: R8 interrupt marks head
    alloc_one(1, 3, 110, 30, 0); alloc_one(1, 4, 111, 31, 0);
    irq_mark = 1; @(negedge clk); irq_mark = 0;
    f0 = nflush;
    done_one(1, 0); done_one(0, 0);
    idle(3);
    chk(nflush - f0 == 1, "R8 interrupt causes flush", nflush - f0, 1);
    chk(count_at_flush == 1, "R8 only head retires", count_at_flush, 1);

    // S7: R9 allocation in the retire cycle of a marked entry is dropped
    alloc_one(1, 6, 120, 60, 0); alloc_one(1, 7, 121, 61, 0);
    done_one(0, 1);
    alloc_one(1, 8, 122, 62, 0);
    idle(1);
    chk(alloc_idx == 0, "R9 dropped allocation leaves index 0", alloc_idx, 0);
    idle(3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule